// File: doc/BRIEF.md
# I2C-to-SPI Command Bridge

This block sits between a two-wire I2C bus and a group of SPI filter devices. To the bus master it looks like a write-only I2C slave with a fixed 7-bit address. To the filter devices it is an SPI master that only writes. The master sends a transaction with the bridge address and the write bit. The first data byte names the target device, and the second byte is a command code. For the two write commands that are implemented, the bridge pulls the chosen target's active-low chip select low. It then shifts every following byte out on MOSI, most significant bit first. Only the eight data bits of each byte are sent, so the acknowledge slots of the I2C stream never reach the SPI side.

The bridge samples SCL and SDA through a synchroniser clocked by the system clock. It drives SDA only through an open-drain pull-low enable. The SPI clock is the system clock divided by the even parameter `CLK_DIV`, and it idles low. A STOP or a repeated START closes the running command. If an implemented command was closed before it carried its minimum payload, a saturating error counter steps up by one.

Top module: `i2c_spi_cmd_bridge`

## Requirements
- R1: While reset is held, every chip select is high, `spi_sclk` is low, `sda_oe` is low and `err_cnt` is zero.
- R2: The bridge acknowledges (pulls SDA low during the ninth clock) only an address byte whose upper seven bits equal `SLAVE_ADDR` and whose last bit is 0 (write). Any other address byte is not acknowledged, and the rest of that transaction is ignored (no ACK, no chip select, no SPI clock) until the next START.
- R3: After a matching address, every data byte is acknowledged.
- R4: Data byte 0 is the target index. An index of `NUM_TGT` or more selects no chip select and produces no SPI traffic, but the bytes are still acknowledged.
- R5: Command code 0x82 (write configuration) drives the chip select at bit position equal to the target index low. Each later byte is then forwarded on MOSI, MSB first, with exactly eight SCLK pulses per byte. The command byte itself is not forwarded. The minimum payload is one byte.
- R6: Command code 0x86 (write coefficient) behaves like 0x82, but its minimum payload is two bytes.
- R7: Every other command code (including 0x88, 0x89 and 0x90) is acknowledged but causes no chip select and no SPI traffic.
- R8: SPI mode 0: `spi_sclk` idles low and pulses only while a chip select is low. MOSI changes only while SCLK is low. Consecutive rising edges within a byte are `CLK_DIV` system clocks apart.
- R9: A STOP releases the chip select once the last forwarded bit has been shifted.
- R10: When an implemented command is closed with fewer payload bytes than its minimum, `err_cnt` rises by exactly one (saturating), and the chip select is still released.
- R11: A repeated START closes the running command in the same way as a STOP, and it starts a new address phase.
- R12: At most one chip select is low at any time.
- R13: `sda_oe` is asserted only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level (wired-AND bus) |
| sda_oe | output | 1 | Pull SDA low when 1 (open drain) |
| spi_sclk | output | 1 | SPI serial clock, idle low |
| spi_mosi | output | 1 | SPI serial data out |
| spi_cs_n | output | NUM_TGT | Active-low chip selects, one per target |
| err_cnt | output | ERR_W | Count of short implemented commands |

## Verification
The command path is driven with full transactions that vary the target index, the command code and the payload length. Comparing forwarded bytes and chip-select activity shows whether each code is treated as implemented or ignored. It also shows that payload bytes land on the correct select line, with no acknowledge bits mixed in. Address variants (wrong address, read bit) separate a matched transaction from one that must be ignored. Payloads one byte short of the minimum, and an out-of-range target, separate the error-count path from plain forwarding. A repeated START between two commands shows that the first command is closed and the second is addressed anew.

// File: rtl/i2cspi_pkg.sv
package i2cspi_pkg;

  typedef enum logic [1:0] {
    RX_IDLE   = 2'd0,
    RX_ADDR   = 2'd1,
    RX_DATA   = 2'd2,
    RX_IGNORE = 2'd3
  } rx_state_e;

  localparam logic [7:0] OP_CFG_WRITE  = 8'h82;
  localparam logic [7:0] OP_COEF_WRITE = 8'h86;

  // Minimum number of payload bytes an opcode needs; zero for non-forwarding codes
  function automatic logic [1:0] op_min_len(input logic [7:0] op);
    case (op)
      OP_CFG_WRITE:  op_min_len = 2'd1;
      OP_COEF_WRITE: op_min_len = 2'd2;
      default:       op_min_len = 2'd0;
    endcase
  endfunction

  function automatic logic op_forwards(input logic [7:0] op);
    op_forwards = (op == OP_CFG_WRITE) || (op == OP_COEF_WRITE);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // index 1 = SCL, index 0 = SDA
  logic [1:0] raw_in;
  logic [1:0] synced;
  logic [1:0] prev_q;

  assign raw_in = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], raw_in[g]};
    end
    assign synced[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b11;
    else        prev_q <= synced;
  end

  assign sda_lvl   = synced[0];
  assign scl_rise  = synced[1] & ~prev_q[1];
  assign scl_fall  = ~synced[1] & prev_q[1];
  assign start_det = synced[1] & prev_q[1] & prev_q[0] & ~synced[0];
  assign stop_det  = synced[1] & prev_q[1] & ~prev_q[0] & synced[0];

endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx
  import i2cspi_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h2A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  output logic       sda_oe,
  output logic       byte_vld,
  output logic [7:0] byte_data
);
  rx_state_e  state_q, state_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic       ack_q, ack_d;
  logic [7:0] full;

  assign full      = {sh_q[6:0], sda_lvl};
  assign byte_data = full;
  assign sda_oe    = ack_q;

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    ack_d    = ack_q;
    byte_vld = 1'b0;
    if (start_det) begin
      state_d = RX_ADDR;
      bit_d   = 4'd0;
      ack_d   = 1'b0;
    end else if (stop_det) begin
      state_d = RX_IDLE;
      bit_d   = 4'd0;
      ack_d   = 1'b0;
    end else if (state_q == RX_ADDR || state_q == RX_DATA) begin
      if (scl_rise) begin
        if (bit_q < 4'd8) begin
          sh_d  = full;
          bit_d = bit_q + 4'd1;
          if (bit_q == 4'd7) begin
            if (state_q == RX_DATA) byte_vld = 1'b1;
            else if (full[7:1] != SLAVE_ADDR || full[0]) state_d = RX_IGNORE;
          end
        end else begin
          bit_d = 4'd9;          // acknowledge clock is high
        end
      end else if (scl_fall) begin
        if (bit_q == 4'd8) begin
          ack_d = 1'b1;
        end else if (bit_q == 4'd9) begin
          ack_d = 1'b0;
          bit_d = 4'd0;
          if (state_q == RX_ADDR) state_d = RX_DATA;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      bit_q   <= 4'd0;
      sh_q    <= 8'd0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      ack_q   <= ack_d;
    end
  end

endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
  import i2cspi_pkg::*;
#(
  parameter int NUM_TGT = 4,
  parameter int ERR_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_vld,
  input  logic [7:0]         byte_data,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic               spi_busy,
  output logic               load_vld,
  output logic [7:0]         load_byte,
  output logic [NUM_TGT-1:0] cs_n,
  output logic [ERR_W-1:0]   err_cnt
);
  localparam int         TGT_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;
  localparam logic [7:0] TGT_LIM = 8'(NUM_TGT);

  logic [1:0]       idx_q, idx_d;
  logic [TGT_W-1:0] tgt_q, tgt_d;
  logic             tgt_ok_q, tgt_ok_d;
  logic             live_q, live_d;
  logic             cs_on_q, cs_on_d;
  logic             end_q, end_d;
  logic [1:0]       pay_q, pay_d;
  logic [1:0]       need_q, need_d;
  logic [ERR_W-1:0] err_q, err_d;

  assign err_cnt   = err_q;
  assign load_byte = byte_data;

  always_comb begin
    idx_d    = idx_q;
    tgt_d    = tgt_q;
    tgt_ok_d = tgt_ok_q;
    live_d   = live_q;
    cs_on_d  = cs_on_q;
    end_d    = end_q;
    pay_d    = pay_q;
    need_d   = need_q;
    err_d    = err_q;
    load_vld = 1'b0;
    if (start_det || stop_det) begin
      idx_d = 2'd0;
      if (live_q) begin
        live_d = 1'b0;
        end_d  = 1'b1;
        if (pay_q < need_q && err_q != '1) err_d = err_q + ERR_W'(1);
      end
    end else if (byte_vld) begin
      case (idx_q)
        2'd0: begin
          tgt_d    = byte_data[TGT_W-1:0];
          tgt_ok_d = (byte_data < TGT_LIM);
          idx_d    = 2'd1;
        end
        2'd1: begin
          idx_d = 2'd2;
          if (op_forwards(byte_data) && tgt_ok_q) begin
            live_d  = 1'b1;
            cs_on_d = 1'b1;
            end_d   = 1'b0;
            pay_d   = 2'd0;
            need_d  = op_min_len(byte_data);
          end
        end
        default: begin
          if (live_q) begin
            load_vld = 1'b1;
            if (pay_q != 2'd3) pay_d = pay_q + 2'd1;
          end
        end
      endcase
    end else if (end_q && !spi_busy) begin
      cs_on_d = 1'b0;
      end_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= 2'd0;
      tgt_q    <= '0;
      tgt_ok_q <= 1'b0;
      live_q   <= 1'b0;
      cs_on_q  <= 1'b0;
      end_q    <= 1'b0;
      pay_q    <= 2'd0;
      need_q   <= 2'd0;
      err_q    <= '0;
    end else begin
      idx_q    <= idx_d;
      tgt_q    <= tgt_d;
      tgt_ok_q <= tgt_ok_d;
      live_q   <= live_d;
      cs_on_q  <= cs_on_d;
      end_q    <= end_d;
      pay_q    <= pay_d;
      need_q   <= need_d;
      err_q    <= err_d;
    end
  end

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_cs
    assign cs_n[g] = ~(cs_on_q && (tgt_q == TGT_W'(g)));
  end

endmodule

// File: rtl/spi_byte_tx.sv
module spi_byte_tx #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_vld,
  input  logic [7:0] load_byte,
  output logic       sclk,
  output logic       mosi,
  output logic       busy
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic             busy_q, busy_d;
  logic             sclk_q, sclk_d;
  logic [7:0]       sh_q, sh_d;
  logic [2:0]       bit_q, bit_d;
  logic [CNT_W-1:0] div_q, div_d;

  assign busy = busy_q;
  assign sclk = sclk_q;
  assign mosi = busy_q & sh_q[7];

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    div_d  = div_q;
    if (!busy_q) begin
      if (load_vld) begin
        busy_d = 1'b1;
        sh_d   = load_byte;
        bit_d  = 3'd0;
        div_d  = '0;
        sclk_d = 1'b0;
      end
    end else if (div_q == CNT_W'(HALF - 1)) begin
      div_d = '0;
      if (!sclk_q) begin
        sclk_d = 1'b1;                 // target samples here
      end else begin
        sclk_d = 1'b0;                 // data advances on this edge
        if (bit_q == 3'd7) begin
          busy_d = 1'b0;
        end else begin
          bit_d = bit_q + 3'd1;
          sh_d  = {sh_q[6:0], 1'b0};
        end
      end
    end else begin
      div_d = div_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      sh_q   <= 8'd0;
      bit_q  <= 3'd0;
      div_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      div_q  <= div_d;
    end
  end

endmodule

// File: rtl/i2c_spi_cmd_bridge.sv
module i2c_spi_cmd_bridge #(
  parameter logic [6:0] SLAVE_ADDR  = 7'h2A,
  parameter int         NUM_TGT     = 4,
  parameter int         CLK_DIV     = 4,
  parameter int         ERR_W       = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic               spi_sclk,
  output logic               spi_mosi,
  output logic [NUM_TGT-1:0] spi_cs_n,
  output logic [ERR_W-1:0]   err_cnt
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic       byte_vld;
  logic [7:0] byte_data;
  logic       load_vld;
  logic [7:0] load_byte;
  logic       spi_busy;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_byte_rx #(.SLAVE_ADDR(SLAVE_ADDR)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .byte_vld(byte_vld), .byte_data(byte_data)
  );

  cmd_sequencer #(.NUM_TGT(NUM_TGT), .ERR_W(ERR_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .start_det(start_det), .stop_det(stop_det), .spi_busy(spi_busy),
    .load_vld(load_vld), .load_byte(load_byte),
    .cs_n(spi_cs_n), .err_cnt(err_cnt)
  );

  spi_byte_tx #(.CLK_DIV(CLK_DIV)) u_spi (
    .clk(clk), .rst_n(rst_int_n), .load_vld(load_vld), .load_byte(load_byte),
    .sclk(spi_sclk), .mosi(spi_mosi), .busy(spi_busy)
  );

endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
  parameter int NUM_TGT = 4,
  parameter int ERR_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_i,
  input logic               sda_oe,
  input logic               spi_sclk,
  input logic               spi_mosi,
  input logic [NUM_TGT-1:0] spi_cs_n,
  input logic [ERR_W-1:0]   err_cnt
);
  // R12
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  // R8
  sclk_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> (spi_cs_n != '1));

  // R8
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  // R10
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != $past(err_cnt)) |-> (err_cnt == $past(err_cnt) + ERR_W'(1)));

  // R13
  ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

endmodule

bind i2c_spi_cmd_bridge bridge_chk #(.NUM_TGT(NUM_TGT), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .err_cnt(err_cnt)
);

// File: tb/i2c_spi_cmd_bridge_bench.sv
`timescale 1ns/1ps
module i2c_spi_cmd_bridge_bench;
  localparam int         NT    = 4;
  localparam int         DIV   = 4;
  localparam int         EW    = 8;
  localparam logic [6:0] ADDR  = 7'h2A;
  localparam int         T     = 20;   // SCL half period in system clocks

  typedef struct packed {
    logic [6:0]  addr;
    logic        rw;
    logic [7:0]  tgt;
    logic [7:0]  cmd;
    logic [1:0]  npay;
    logic [23:0] pay;
    logic        e_ack;
    logic        e_cs;
    logic [3:0]  e_tgt;
    logic [1:0]  e_nfwd;
    logic        e_err;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{7'h2A, 1'b0, 8'd0, 8'h82, 2'd1, 24'hA50000, 1'b1, 1'b1, 4'd0,  2'd1, 1'b0}, // R5
    '{7'h2A, 1'b0, 8'd2, 8'h86, 2'd2, 24'h123400, 1'b1, 1'b1, 4'd2,  2'd2, 1'b0}, // R6
    '{7'h2A, 1'b0, 8'd3, 8'h82, 2'd3, 24'h0FF05A, 1'b1, 1'b1, 4'd3,  2'd3, 1'b0}, // R5 R9
    '{7'h2A, 1'b0, 8'd1, 8'h88, 2'd1, 24'h550000, 1'b1, 1'b0, 4'd15, 2'd0, 1'b0}, // R7
    '{7'h2A, 1'b0, 8'd1, 8'h90, 2'd0, 24'h000000, 1'b1, 1'b0, 4'd15, 2'd0, 1'b0}, // R7
    '{7'h2B, 1'b0, 8'd0, 8'h82, 2'd1, 24'hA50000, 1'b0, 1'b0, 4'd15, 2'd0, 1'b0}, // R2
    '{7'h2A, 1'b1, 8'd0, 8'h82, 2'd1, 24'hA50000, 1'b0, 1'b0, 4'd15, 2'd0, 1'b0}, // R2
    '{7'h2A, 1'b0, 8'd1, 8'h86, 2'd1, 24'hC30000, 1'b1, 1'b1, 4'd1,  2'd1, 1'b1}, // R10
    '{7'h2A, 1'b0, 8'd0, 8'h82, 2'd0, 24'h000000, 1'b1, 1'b1, 4'd15, 2'd0, 1'b1}, // R10
    '{7'h2A, 1'b0, 8'd5, 8'h82, 2'd1, 24'h770000, 1'b1, 1'b0, 4'd15, 2'd0, 1'b0}, // R4
    '{7'h2A, 1'b0, 8'd1, 8'h89, 2'd2, 24'hFF0100, 1'b1, 1'b0, 4'd15, 2'd0, 1'b0}, // R7
    '{7'h2A, 1'b0, 8'd1, 8'h82, 2'd2, 24'h3C9600, 1'b1, 1'b1, 4'd1,  2'd2, 1'b0}  // R5 R3
  };

  logic          clk;
  logic          rst_n;
  logic          m_scl, m_sda;
  logic          sda_bus;
  logic          sda_oe, spi_sclk, spi_mosi;
  logic [NT-1:0] spi_cs_n;
  logic [EW-1:0] err_cnt;

  assign sda_bus = m_sda & ~sda_oe;

  i2c_spi_cmd_bridge #(.SLAVE_ADDR(ADDR), .NUM_TGT(NT), .CLK_DIV(DIV), .ERR_W(EW)) u_i2c_spi_cmd_bridge (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .err_cnt(err_cnt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  // ---------------- SPI / bus monitor ----------------
  logic [7:0] cap_byte [64];
  int         cap_tgt  [64];
  int cap_n = 0, cs_events = 0, overlap = 0, bad_oe = 0, bad_gap = 0, bad_mosi = 0, sclk_nocs = 0;
  int bitpos = 0, gap = 0, byte_tgt = 15;
  logic [7:0] cur = 8'd0;
  logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_oe = 1'b0, prev_idle = 1'b1;

  always @(negedge clk) begin
    int low, who;
    low = 0; who = 15;
    for (int k = 0; k < NT; k++) if (!spi_cs_n[k]) begin low++; who = k; end
    if (low != 1) who = 15;
    if (rst_n) begin
      if (low > 1) overlap++;
      if (prev_idle && low > 0) cs_events++;
      if (sda_oe && !prev_oe && m_scl) bad_oe++;
      if (spi_sclk && low == 0) sclk_nocs++;
      if (spi_sclk && prev_sclk && spi_mosi != prev_mosi) bad_mosi++;
      gap++;
      if (spi_sclk && !prev_sclk) begin
        if (bitpos != 0 && gap != DIV) bad_gap++;
        gap = 0;
        cur = {cur[6:0], spi_mosi};
        if (bitpos == 0) byte_tgt = who;
        else if (who != byte_tgt) byte_tgt = 15;
        if (bitpos == 7 && cap_n < 64) begin
          cap_byte[cap_n] = cur;
          cap_tgt[cap_n]  = byte_tgt;
          cap_n++;
        end
        bitpos = (bitpos + 1) % 8;
      end
    end
    prev_sclk = spi_sclk;
    prev_mosi = spi_mosi;
    prev_oe   = sda_oe;
    prev_idle = (low == 0);
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; waitc(T);
    m_scl = 1'b1; waitc(T);
    m_sda = 1'b0; waitc(T);
    m_scl = 1'b0; waitc(T);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; waitc(T);
    m_scl = 1'b1; waitc(T);
    m_sda = 1'b1; waitc(T);
  endtask

  task automatic i2c_bit(input logic b, output logic r);
    m_sda = b; waitc(T);
    m_scl = 1'b1; waitc(T/2);
    r = sda_bus; waitc(T/2);
    m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) i2c_bit(b[i], r);
    i2c_bit(1'b1, r);
    ack = ~r;
    waitc(T);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    waitc(150000);
    if (!done) begin
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nbad + 1);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic a;
    logic all_ok;
    int base, ev0;
    logic [EW-1:0] e0;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    waitc(5);
    // R1 reset state
    chk("R1 cs", spi_cs_n == '1, spi_cs_n, {NT{1'b1}});
    chk("R1 sclk/oe", !spi_sclk && !sda_oe, {spi_sclk, sda_oe}, 0);
    chk("R1 err", err_cnt == '0, err_cnt, 0);
    rst_n = 1'b1;
    waitc(20);

    for (int v = 0; v < NV; v++) begin
      vec_t vv;
      vv = VECS[v];
      base = cap_n; ev0 = cs_events; e0 = err_cnt;
      i2c_start();
      send_byte({vv.addr, vv.rw}, a);
      chk("R2 address ack", a == vv.e_ack, a, vv.e_ack);
      all_ok = 1'b1;
      send_byte(vv.tgt, a); if (a != vv.e_ack) all_ok = 1'b0;
      send_byte(vv.cmd, a); if (a != vv.e_ack) all_ok = 1'b0;
      for (int p = 0; p < int'(vv.npay); p++) begin
        send_byte(vv.pay[23 - 8*p -: 8], a);
        if (a != vv.e_ack) all_ok = 1'b0;
      end
      chk("R3 data ack", all_ok, all_ok, 1);
      i2c_stop();
      waitc(20);
      chk("R4 R5 R6 R7 select event", (cs_events - ev0) == int'(vv.e_cs), cs_events - ev0, vv.e_cs);
      chk("R5 R6 R7 forwarded bytes", (cap_n - base) == int'(vv.e_nfwd), cap_n - base, vv.e_nfwd);
      for (int k = 0; k < int'(vv.e_nfwd); k++) begin
        if (base + k < cap_n) begin
          chk("R5 R6 byte value", cap_byte[base+k] == vv.pay[23 - 8*k -: 8], cap_byte[base+k], vv.pay[23 - 8*k -: 8]);
          chk("R5 R12 byte target", cap_tgt[base+k] == int'(vv.e_tgt), cap_tgt[base+k], vv.e_tgt);
        end
      end
      chk("R9 release at stop", spi_cs_n == '1, spi_cs_n, {NT{1'b1}});
      chk("R10 error step", err_cnt == e0 + EW'(vv.e_err), err_cnt, e0 + EW'(vv.e_err));
      waitc(T);
    end

    // R11 repeated START closes a short coefficient write, then a new command runs
    base = cap_n; ev0 = cs_events; e0 = err_cnt;
    i2c_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'd0, a);
    send_byte(8'h86, a);
    send_byte(8'hAA, a);
    i2c_start();
    waitc(10);
    chk("R11 select released at repeated start", spi_cs_n == '1, spi_cs_n, {NT{1'b1}});
    chk("R11 R10 short command counted", err_cnt == e0 + EW'(1), err_cnt, e0 + EW'(1));
    send_byte({ADDR, 1'b0}, a);
    chk("R11 new address phase acked", a == 1'b1, a, 1);
    send_byte(8'd2, a);
    send_byte(8'h82, a);
    send_byte(8'h55, a);
    i2c_stop();
    waitc(20);
    chk("R11 bytes forwarded", cap_n - base == 2, cap_n - base, 2);
    if (cap_n - base == 2) begin
      chk("R11 first byte", cap_byte[base] == 8'hAA && cap_tgt[base] == 0, {cap_byte[base], 8'(cap_tgt[base])}, 16'hAA00);
      chk("R11 second byte", cap_byte[base+1] == 8'h55 && cap_tgt[base+1] == 2, {cap_byte[base+1], 8'(cap_tgt[base+1])}, 16'h5502);
    end
    chk("R11 two select events", cs_events - ev0 == 2, cs_events - ev0, 2);
    chk("R11 no extra error", err_cnt == e0 + EW'(1), err_cnt, e0 + EW'(1));

    // whole-run observations
    chk("R12 select overlap", overlap == 0, overlap, 0);
    chk("R13 ack while SCL high", bad_oe == 0, bad_oe, 0);
    chk("R8 bit spacing", bad_gap == 0, bad_gap, 0);
    chk("R8 MOSI moved while SCLK high", bad_mosi == 0, bad_mosi, 0);
    chk("R8 SCLK without select", sclk_nocs == 0, sclk_nocs, 0);
    chk("R8 SCLK idle low", spi_sclk == 1'b0, spi_sclk, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

endmodule